// File: doc/BRIEF.md
# Prescaled Dual-Channel Interval Timer

This block is a register-mapped interval timer with a parameterised number of channels (two by default), all clocked by one functional clock. Each channel holds a 16-bit reload value and a 16-bit down-counter. A power-of-two prescaler divides the functional clock into the channel's tick. On the tick that finds the counter at zero, the channel raises an expiry flag. It then either reloads and keeps going, or stops and clears its own run bit.

Software reaches the channels through a simple synchronous port with 16-bit data. Each channel has its own 0x80-byte window. Reads are registered. Expiry flags are cleared by writing a one to them. Each channel drives its own interrupt line, which is the expiry flag gated by an interrupt-enable bit.

Top module: `ptm_top`

## Requirements
- R1: After reset every channel register reads 0x0000, the read data output is 0 and all interrupt lines are low.
- R2: Channel c (from 0) has its window at byte address 0x80*(c+1). Inside the window, offset 0x0 is control, 0x4 is status, 0x8 is reload and 0xC is count. Read data for a request made at a clock edge appears on `bus_rdata` after that edge and is 0 in a cycle that follows no read. Addresses below 0x80, windows beyond the last channel and other offsets read 0, and writes to them are ignored.
- R3: Control bit 8 is the interrupt enable, bit 5 the run bit, bit 4 the one-shot select, and bits [3:0] the prescaler code. A control read returns exactly these bits, with all others 0.
- R4: With prescaler code n from 0 to 8, a running channel advances once every 2^n clock cycles. Codes 9 to 15 behave as code 8 (256 cycles).
- R5: On each advance a nonzero count decreases by one. An advance that finds the count at 0 is an expiry, so the first expiry comes (reload+1)*2^n cycles after the run bit is set.
- R6: With one-shot clear, an expiry copies the reload value into the count and the channel keeps running.
- R7: With one-shot set, an expiry clears the run bit (control readback bit 5 becomes 0) and the count stays at 0.
- R8: Writing the run bit as 1 while it is 0 copies the reload value into the count and restarts the prescaler. A control write to a channel that is already running does not reload, and the channel does not advance in a cycle that carries a control write to it. With the run bit clear, the count holds.
- R9: Status bit 0 is set on expiry. Writing a 1 to it clears it, and writing a 0 has no effect. When an expiry and a clear fall on the same edge, the flag stays set.
- R10: A channel's interrupt line is high exactly while its status bit and its interrupt-enable bit are both 1.
- R11: Writes to the count offset are ignored. A reload write does not alter a running count. An access to one channel's window never changes another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock shared by all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | NUM_CH (2) | Per-channel interrupt lines |

## Verification
A register write takes effect at the edge that samples it. Read data is due on `bus_rdata` one edge after the request. An expiry shows on status and on the interrupt line right after the edge on which the expiring tick falls, which is (reload+1)*2^n edges after the enabling write. The bench drives on falling edges and compares the interrupt lines and read data against its behavioural model on every falling edge, so each result is taken half a cycle after the edge that produced it. Directed checks count edges from the enabling write to the interrupt, and line reads up against known tick positions, so the reload, one-shot, set-over-clear and no-reload cases are each hit on the exact cycle.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    localparam int DATA_W  = 16;
    localparam int CNT_W   = 16;
    localparam int CODE_W  = 4;
    localparam int OFF_W   = 7;

    localparam int BIT_IE  = 8;
    localparam int BIT_RUN = 5;
    localparam int BIT_OS  = 4;

    localparam logic [OFF_W-1:0] OFF_CTRL  = 7'h00;
    localparam logic [OFF_W-1:0] OFF_STAT  = 7'h04;
    localparam logic [OFF_W-1:0] OFF_LOAD  = 7'h08;
    localparam logic [OFF_W-1:0] OFF_COUNT = 7'h0C;

    typedef struct packed {
        logic              ie;
        logic              run;
        logic              oneshot;
        logic [CODE_W-1:0] code;
        logic              status;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  count;
    } chan_state_t;

    typedef struct packed {
        logic ctrl_wr;
        logic stat_wr;
        logic load_wr;
    } chan_wr_t;

endpackage

// File: rtl/ptm_prescaler.sv
module ptm_prescaler
    import ptm_pkg::*;
#(
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    localparam int DIV_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       state_d, state_q;
    logic [CODE_W-1:0] eff_code;
    logic [DIV_W:0]    lim_wide;
    logic [DIV_W-1:0]  limit;

    always_comb begin
        eff_code = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        lim_wide = ({{DIV_W{1'b0}}, 1'b1} << eff_code) - 1'b1;
        limit    = lim_wide[DIV_W-1:0];
        tick     = run && (state_q.cnt == limit);
        state_d  = state_q;
        if (restart) begin
            state_d.cnt = '0;
        end else if (run) begin
            state_d.cnt = tick ? '0 : state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n) tick |=> state_q.cnt == '0); // R4
    AST_PRE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run && !restart) |=> $stable(state_q.cnt)); // R4

endmodule

// File: rtl/ptm_channel.sv
module ptm_channel
    import ptm_pkg::*;
#(
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] stat_rd,
    output logic [DATA_W-1:0] load_rd,
    output logic [DATA_W-1:0] count_rd,
    output logic              irq
);

    chan_state_t state_d, state_q;
    logic        tick;
    logic        run_adv;
    logic        restart;
    logic        expire;
    logic        clr;

    assign run_adv = state_q.run && !wr.ctrl_wr;
    assign restart = wr.ctrl_wr && !state_q.run && wdata[BIT_RUN];

    ptm_prescaler #(.MAX_CODE(MAX_CODE)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_adv),
        .restart (restart),
        .code    (state_q.code),
        .tick    (tick)
    );

    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        clr     = wr.stat_wr && wdata[0];
        if (wr.ctrl_wr) begin
            state_d.ie      = wdata[BIT_IE];
            state_d.run     = wdata[BIT_RUN];
            state_d.oneshot = wdata[BIT_OS];
            state_d.code    = wdata[CODE_W-1:0];
            if (restart) begin
                state_d.count = state_q.reload;
            end
        end else if (tick) begin
            if (state_q.count == '0) begin
                expire = 1'b1;
                if (state_q.oneshot) begin
                    state_d.run = 1'b0;
                end else begin
                    state_d.count = state_q.reload;
                end
            end else begin
                state_d.count = state_q.count - 1'b1;
            end
        end
        if (wr.load_wr) begin
            state_d.reload = wdata[CNT_W-1:0];
        end
        state_d.status = expire | (state_q.status & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ctrl_rd                 = '0;
        ctrl_rd[BIT_IE]         = state_q.ie;
        ctrl_rd[BIT_RUN]        = state_q.run;
        ctrl_rd[BIT_OS]         = state_q.oneshot;
        ctrl_rd[CODE_W-1:0]     = state_q.code;
        stat_rd                 = '0;
        stat_rd[0]              = state_q.status;
        load_rd                 = DATA_W'(state_q.reload);
        count_rd                = DATA_W'(state_q.count);
    end

    assign irq = state_q.status & state_q.ie;

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n) (tick && state_q.count != '0) |=> state_q.count == CNT_W'($past(state_q.count) - 1'b1)); // R5
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) (tick && state_q.count == '0 && !state_q.oneshot) |=> (state_q.count == $past(state_q.reload) && state_q.run)); // R6
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n) (tick && state_q.count == '0 && state_q.oneshot) |=> (!state_q.run && state_q.count == '0)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!state_q.run && !wr.ctrl_wr) |=> $stable(state_q.count)); // R8
    AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (tick && state_q.count == '0) |=> state_q.status); // R9
    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (wr.stat_wr && wdata[0] && !tick) |=> !state_q.status); // R9
    AST_NO_TICK_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n) wr.ctrl_wr |-> !tick); // R8

endmodule

// File: rtl/ptm_bus_port.sv
module ptm_bus_port
    import ptm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd,
    input  logic [NUM_CH-1:0][DATA_W-1:0] stat_rd,
    input  logic [NUM_CH-1:0][DATA_W-1:0] load_rd,
    input  logic [NUM_CH-1:0][DATA_W-1:0] count_rd,
    output chan_wr_t [NUM_CH-1:0]         wr_o,
    output logic [DATA_W-1:0]             rdata
);

    localparam int WIN_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } port_state_t;

    port_state_t          state_d, state_q;
    logic [WIN_W-1:0]     win;
    logic [OFF_W-1:0]     off;
    logic [NUM_CH-1:0]    hit;
    logic [DATA_W-1:0]    rd_val;
    logic [3*NUM_CH-1:0]  strobes;

    assign win = addr[ADDR_W-1:OFF_W];
    assign off = addr[OFF_W-1:0];

    always_comb begin
        rd_val  = '0;
        strobes = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            hit[c]             = (win == WIN_W'(c + 1));
            wr_o[c].ctrl_wr    = sel && wr && hit[c] && (off == OFF_CTRL);
            wr_o[c].stat_wr    = sel && wr && hit[c] && (off == OFF_STAT);
            wr_o[c].load_wr    = sel && wr && hit[c] && (off == OFF_LOAD);
            strobes[3*c +: 3]  = {wr_o[c].ctrl_wr, wr_o[c].stat_wr, wr_o[c].load_wr};
            if (hit[c]) begin
                case (off)
                    OFF_CTRL:  rd_val = ctrl_rd[c];
                    OFF_STAT:  rd_val = stat_rd[c];
                    OFF_LOAD:  rd_val = load_rd[c];
                    OFF_COUNT: rd_val = count_rd[c];
                    default:   rd_val = '0;
                endcase
            end
        end
        state_d.rdata = (sel && !wr) ? rd_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = state_q.rdata;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(strobes)); // R11
    AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !(sel && !wr) |=> rdata == '0); // R2

endmodule

// File: rtl/ptm_top.sv
module ptm_top
    import ptm_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int ADDR_W   = 10,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int WIN_COUNT = 1 << (ADDR_W - OFF_W);

    chan_wr_t [NUM_CH-1:0]         wr_vec;
    logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd;
    logic [NUM_CH-1:0][DATA_W-1:0] stat_rd;
    logic [NUM_CH-1:0][DATA_W-1:0] load_rd;
    logic [NUM_CH-1:0][DATA_W-1:0] count_rd;

    initial begin
        if (NUM_CH + 1 > WIN_COUNT) begin
            $error("address width too small for channel count");
        end
    end

    ptm_bus_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .ctrl_rd  (ctrl_rd),
        .stat_rd  (stat_rd),
        .load_rd  (load_rd),
        .count_rd (count_rd),
        .wr_o     (wr_vec),
        .rdata    (bus_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ptm_channel #(.MAX_CODE(MAX_CODE)) i_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_vec[c]),
            .wdata    (bus_wdata),
            .ctrl_rd  (ctrl_rd[c]),
            .stat_rd  (stat_rd[c]),
            .load_rd  (load_rd[c]),
            .count_rd (count_rd[c]),
            .irq      (irq[c])
        );
    end

endmodule

// File: tb/test_ptm_top.sv
module test_ptm_top;

    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NCH-1:0] irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    ptm_top i_ptm_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #4 clk = ~clk;

    // behavioural reference model
    int m_cnt [NCH];
    int m_load[NCH];
    int m_pre [NCH];
    int m_code[NCH];
    bit m_run [NCH];
    bit m_ie  [NCH];
    bit m_os  [NCH];
    bit m_st  [NCH];
    int exp_rd = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            exp_rd = 0;
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] = 0; m_load[c] = 0; m_pre[c] = 0; m_code[c] = 0;
                m_run[c] = 0; m_ie[c] = 0; m_os[c] = 0; m_st[c] = 0;
            end
        end else begin
            int w;
            int o;
            w = int'(bus_addr) / 128;
            o = int'(bus_addr) % 128;
            exp_rd = 0;
            for (int c = 0; c < NCH; c++) begin
                if (bus_sel && !bus_wr && w == c + 1) begin
                    if (o == 0) exp_rd = (int'(m_ie[c]) << 8) | (int'(m_run[c]) << 5) | (int'(m_os[c]) << 4) | m_code[c];
                    else if (o == 4) exp_rd = int'(m_st[c]);
                    else if (o == 8) exp_rd = m_load[c];
                    else if (o == 12) exp_rd = m_cnt[c];
                end
            end
            for (int c = 0; c < NCH; c++) begin
                bit hitw;
                bit expire;
                int div;
                hitw = bus_sel && bus_wr && (w == c + 1);
                expire = 0;
                if (hitw && o == 0) begin
                    if (!m_run[c] && bus_wdata[5]) begin
                        m_cnt[c] = m_load[c];
                        m_pre[c] = 0;
                    end
                    m_run[c]  = bus_wdata[5];
                    m_ie[c]   = bus_wdata[8];
                    m_os[c]   = bus_wdata[4];
                    m_code[c] = int'(bus_wdata[3:0]);
                end else if (m_run[c]) begin
                    div = 1 << ((m_code[c] > 8) ? 8 : m_code[c]);
                    if (m_pre[c] == div - 1) begin
                        m_pre[c] = 0;
                        if (m_cnt[c] == 0) begin
                            expire = 1;
                            if (m_os[c]) m_run[c] = 0;
                            else m_cnt[c] = m_load[c];
                        end else begin
                            m_cnt[c] = m_cnt[c] - 1;
                        end
                    end else begin
                        m_pre[c] = m_pre[c] + 1;
                    end
                end
                if (hitw && o == 8) m_load[c] = int'(bus_wdata);
                if (expire) m_st[c] = 1;
                else if (hitw && o == 4 && bus_wdata[0]) m_st[c] = 0;
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                checks++;
                if (irq[c] !== (m_st[c] & m_ie[c])) begin
                    errors++;
                    $display("FAIL R10 cycle %0d ch%0d irq act=%0b exp=%0b", cyc, c, irq[c], m_st[c] & m_ie[c]);
                end
            end
            checks++;
            if (int'(bus_rdata) != exp_rd) begin
                errors++;
                $display("FAIL R2 cycle %0d rdata act=%h exp=%h", cyc, bus_rdata, exp_rd);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d (0x%h) exp=%0d (0x%h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output int v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        v = int'(bus_rdata);
        bus_sel = 1'b0;
    endtask

    task automatic wait_irq(input int c, output int k);
        k = 0;
        while (irq[c] == 1'b0 && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        int v;
        int k;
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(10'h080, v); chk("R1 ch0 ctrl", v, 0);
        rd(10'h10C, v); chk("R1 ch1 count", v, 0);
        chk("R1 irq", int'(irq), 0);

        // R3 control field readback
        wr(10'h080, 16'hFEDF);
        rd(10'h080, v); chk("R3 ctrl readback", v, 16'h001F);
        wr(10'h080, 16'h0000);

        // R2 unmapped addresses
        wr(10'h188, 16'hFFFF);
        rd(10'h010, v); chk("R2 below first window", v, 0);
        rd(10'h090, v); chk("R2 unused offset", v, 0);
        rd(10'h188, v); chk("R2 window past last channel", v, 0);

        // R5 / R4 auto-reload timing, reload 3, code 2
        wr(10'h088, 16'd3);
        wr(10'h080, 16'h0122);
        wait_irq(0, k); chk("R5 first expiry edges", k, 16);
        rd(10'h084, v); chk("R9 status set", v, 1);
        wr(10'h084, 16'h0000);
        rd(10'h084, v); chk("R9 zero write keeps flag", v, 1);
        wr(10'h084, 16'h0001);
        chk("R9 clear drops irq", int'(irq[0]), 0);
        wait_irq(0, k); chk("R6 next expiry after reload", k, 12);
        rd(10'h080, v); chk("R6 still running", v, 16'h0122);

        // R10 gating by interrupt enable
        wr(10'h080, 16'h0022);
        chk("R10 irq masked", int'(irq[0]), 0);
        rd(10'h084, v); chk("R10 flag kept while masked", v, 1);
        wr(10'h080, 16'h0000);
        wr(10'h084, 16'h0001);

        // R4 codes above 8 act as 256
        wr(10'h108, 16'd0);
        wr(10'h100, 16'h012C);
        wait_irq(1, k); chk("R4 code 12 divides by 256", k, 256);
        wr(10'h100, 16'h0000);
        wr(10'h104, 16'h0001);

        // R7 one-shot
        wr(10'h088, 16'd2);
        wr(10'h080, 16'h0130);
        wait_irq(0, k); chk("R7 one-shot expiry edges", k, 3);
        rd(10'h080, v); chk("R7 run bit self-cleared", v, 16'h0110);
        repeat (20) @(negedge clk);
        rd(10'h08C, v); chk("R7 count parked at zero", v, 0);
        wr(10'h084, 16'h0001);
        wr(10'h080, 16'h0130);
        rd(10'h08C, v); chk("R8 re-enable reloads", v, 2);
        repeat (5) @(negedge clk);
        wr(10'h084, 16'h0001);

        // R8 / R11 running channel
        wr(10'h108, 16'd100);
        wr(10'h100, 16'h0020);
        repeat (10) @(negedge clk);
        wr(10'h100, 16'h0020);
        rd(10'h10C, v); chk("R8 no reload while running", v, 90);
        wr(10'h10C, 16'hAAAA);
        rd(10'h10C, v); chk("R11 count write ignored", v, 88);
        wr(10'h108, 16'd500);
        rd(10'h10C, v); chk("R11 reload write leaves count", v, 86);
        rd(10'h080, v); chk("R11 other channel untouched", v, 16'h0110);
        wr(10'h100, 16'h0000);
        rd(10'h10C, held);
        repeat (10) @(negedge clk);
        rd(10'h10C, v); chk("R8 stopped count holds", v, held);

        // R9 set wins over same-edge clear
        wr(10'h088, 16'd0);
        wr(10'h080, 16'h0130);
        wr(10'h084, 16'h0001);
        chk("R9 expiry beats clear", int'(irq[0]), 1);
        rd(10'h084, v); chk("R9 flag after collision", v, 1);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule